// File: doc/BRIEF.md
# Receive Byte Queue with Live Error Tallies

This block sits between a serial receiver and the logic that drains received characters. Each character arrives as a byte with two flags: one for a parity fault and one for a stop-bit (framing) fault. The block stores all three in a first-in first-out queue. A reader pops the oldest entry and gets its byte and both flags back, one cycle after the pop request.

The block also keeps two counters that follow the queue contents exactly. One counts how many resident entries carry a parity fault. The other counts how many carry a framing fault. Each counter goes up when a flagged entry is accepted and down when a flagged entry leaves. A read-only 16-bit status word reports both tallies, the fill level and a sticky overrun indication. Software can therefore see how many faulty characters are still waiting before it reads them out.

Top module: `rx_err_fifo`

## Requirements
- R1: After `rst_n` is asserted low, `status_o` reads 0 and `pop_data_o`, `pop_perr_o` and `pop_ferr_o` read 0. This reset clears the queue, both tallies and the overrun bit.
- R2: A pop while the queue is non-empty presents the oldest stored entry on `pop_data_o`, `pop_perr_o` and `pop_ferr_o` from the clock edge that accepts the pop. Entries leave in the order they were pushed, each with its own flags.
- R3: `status_o[15:12]` equals the number of resident entries whose parity flag is set, for counts up to 15.
- R4: `status_o[11:8]` equals the number of resident entries whose framing flag is set, saturating at 15.
- R5: When a push and a pop are both accepted on the same edge, the level is unchanged. Each tally moves by (pushed flag) minus (popped flag) in that single cycle.
- R6: `status_o[4:0]` reports the number of resident entries, from 0 to 16. The queue holds 16 entries.
- R7: A push while the queue holds 16 entries and no pop is requested is discarded. In that case the level and the tallies are unchanged, and `status_o[7]` (overrun) becomes 1 and stays 1 until reset.
- R8: A pop while the queue is empty leaves the three pop outputs at their previous values and does not change the level or the tallies.
- R9: A push together with a pop while the queue is full is accepted. The oldest entry leaves, the new one enters, the level stays 16 and overrun is not set.
- R10: A tally whose exact value is 16 reads 15. After one flagged entry leaves it still reads 15, and after a second it reads 14, because the exact value is kept internally.
- R11: `status_o[6:5]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of queue, tallies and overrun |
| push_i | input | 1 | Store the byte and flags presented this cycle |
| push_data_i | input | 8 | Received byte |
| push_perr_i | input | 1 | Parity fault flag of the received byte |
| push_ferr_i | input | 1 | Framing fault flag of the received byte |
| pop_i | input | 1 | Remove the oldest entry |
| pop_data_o | output | 8 | Byte of the most recently popped entry |
| pop_perr_o | output | 1 | Parity flag of the most recently popped entry |
| pop_ferr_o | output | 1 | Framing flag of the most recently popped entry |
| status_o | output | 16 | [15:12] parity tally, [11:8] framing tally, [7] overrun, [6:5] zero, [4:0] level |

## Verification
Short directed bursts of pushes with mixed flags, followed by pops, show whether entries keep their order and whether each flag stays with its own byte. A full load of parity-flagged entries, then an extra push, then a push paired with a pop, separates reported saturation from the exact internal tally and a dropped write from an accepted one. Pops on an empty queue, and pushes paired with pops at empty, middle and full levels, show whether the tallies handle simultaneous increments and decrements. Long random traffic with alternating fill-heavy and drain-heavy phases is compared cycle by cycle against a reference queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Index of each fault kind in the per-entry flag vector
   localparam int ERR_PAR = 0;
   localparam int ERR_FRM = 1;
   localparam int NUM_ERR = 2;

   // Status word layout (decoded by software, so positions are fixed)
   localparam int STAT_W      = 16;
   localparam int STAT_PAR_LSB = 12;
   localparam int STAT_FRM_LSB = 8;
   localparam int STAT_OVR_BIT = 7;
   localparam int STAT_LVL_LSB = 0;
   localparam int STAT_LVL_MAX = 5;
   localparam int STAT_TALLY_W = 4;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int WORD_W = 10,
   parameter int DEPTH  = 16,
   parameter int PTR_W  = 4
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [WORD_W-1:0] rd_word
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_word;
   end

   assign rd_word = mem[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int DEPTH = 16,
   parameter int PTR_W = 4,
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic             push_ok,
   output logic             pop_ok,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [LVL_W-1:0] level,
   output logic             overrun
);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   logic empty, full;

   assign empty   = (level == '0);
   assign full    = (level == FULL_LVL);
   assign pop_ok  = pop & ~empty;
   // a pop on the same edge frees the slot the push needs
   assign push_ok = push & (~full | pop_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level   <= '0;
         overrun <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         unique case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
         if (push && !push_ok) overrun <= 1'b1;
      end
   end
endmodule

// File: rtl/rxq_err_cnt.sv
module rxq_err_cnt #(
   parameter int EXACT_W = 5,
   parameter int REP_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc,
   input  logic               dec,
   output logic [EXACT_W-1:0] exact,
   output logic [REP_W-1:0]   report
);
   localparam logic [EXACT_W-1:0] REP_MAX = EXACT_W'((1 << REP_W) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exact <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   exact <= exact + 1'b1;
            2'b01:   exact <= exact - 1'b1;
            default: exact <= exact;
         endcase
      end
   end

   assign report = (exact > REP_MAX) ? REP_MAX[REP_W-1:0] : exact[REP_W-1:0];
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int REP_W  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push_i,
   input  logic [DATA_W-1:0]         push_data_i,
   input  logic                      push_perr_i,
   input  logic                      push_ferr_i,
   input  logic                      pop_i,
   output logic [DATA_W-1:0]         pop_data_o,
   output logic                      pop_perr_o,
   output logic                      pop_ferr_o,
   output logic [rxq_pkg::STAT_W-1:0] status_o
);
   import rxq_pkg::*;

   localparam int PTR_W   = $clog2(DEPTH);
   localparam int LVL_W   = PTR_W + 1;
   localparam int EXACT_W = LVL_W;
   localparam int WORD_W  = DATA_W + NUM_ERR;

   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rx_err_fifo: DEPTH must be a power of two, at least 2");
   end
   if (LVL_W > STAT_LVL_MAX) begin : g_bad_level
      $error("rx_err_fifo: level does not fit the status field");
   end
   if (REP_W != STAT_TALLY_W) begin : g_bad_rep
      $error("rx_err_fifo: tally width must match the status fields");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("rx_err_fifo: DATA_W must be positive");
   end

   logic               push_ok, pop_ok;
   logic [PTR_W-1:0]   wr_ptr, rd_ptr;
   logic [LVL_W-1:0]   level;
   logic               overrun;
   logic [NUM_ERR-1:0] flags_in, flags_out;
   logic [WORD_W-1:0]  wr_word, rd_word, out_q;
   logic [EXACT_W-1:0] exact  [NUM_ERR];
   logic [REP_W-1:0]   report [NUM_ERR];

   assign flags_in[ERR_PAR] = push_perr_i;
   assign flags_in[ERR_FRM] = push_ferr_i;
   assign wr_word           = {flags_in, push_data_i};
   assign flags_out         = rd_word[DATA_W +: NUM_ERR];

   rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push_i),
      .pop     (pop_i),
      .push_ok (push_ok),
      .pop_ok  (pop_ok),
      .wr_ptr  (wr_ptr),
      .rd_ptr  (rd_ptr),
      .level   (level),
      .overrun (overrun)
   );

   rxq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
      .clk     (clk),
      .wr_en   (push_ok),
      .wr_ptr  (wr_ptr),
      .wr_word (wr_word),
      .rd_ptr  (rd_ptr),
      .rd_word (rd_word)
   );

   for (genvar k = 0; k < NUM_ERR; k++) begin : g_tally
      rxq_err_cnt #(.EXACT_W(EXACT_W), .REP_W(REP_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (push_ok & flags_in[k]),
         .dec    (pop_ok & flags_out[k]),
         .exact  (exact[k]),
         .report (report[k])
      );
   end

   // popped entry is registered; an empty pop leaves it untouched
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= '0;
      else if (pop_ok) out_q <= rd_word;
   end

   assign pop_data_o = out_q[DATA_W-1:0];
   assign pop_perr_o = out_q[DATA_W + ERR_PAR];
   assign pop_ferr_o = out_q[DATA_W + ERR_FRM];

   always_comb begin
      status_o = '0;
      status_o[STAT_PAR_LSB +: REP_W] = report[ERR_PAR];
      status_o[STAT_FRM_LSB +: REP_W] = report[ERR_FRM];
      status_o[STAT_OVR_BIT]          = overrun;
      status_o[STAT_LVL_LSB +: LVL_W] = level;
   end
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
   parameter int DEPTH   = 16,
   parameter int LVL_W   = 5,
   parameter int EXACT_W = 5,
   parameter int WORD_W  = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               push,
   input logic               pop,
   input logic [LVL_W-1:0]   level,
   input logic               overrun,
   input logic [WORD_W-1:0]  out_word,
   input logic [EXACT_W-1:0] par_exact,
   input logic [EXACT_W-1:0] frm_exact,
   input logic [15:0]        status
);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   // R6
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_LVL);

   // R3
   par_within_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      EXACT_W'(par_exact) <= EXACT_W'(level));

   // R4
   frm_within_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      EXACT_W'(frm_exact) <= EXACT_W'(level));

   // R7
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R7
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level == FULL_LVL && push && !pop) |=> (level == FULL_LVL && overrun));

   // R8
   empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0 && pop) |=> $stable(out_word));

   // R8
   empty_pop_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0 && pop && !push) |=> (level == '0 && par_exact == '0 && frm_exact == '0));

   // R5
   paired_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level != '0 && push && pop) |=> $stable(level));

   // R11
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[6:5] == 2'b00);
endmodule

bind rx_err_fifo rx_err_fifo_chk #(
   .DEPTH   (DEPTH),
   .LVL_W   (LVL_W),
   .EXACT_W (EXACT_W),
   .WORD_W  (WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .push      (push_i),
   .pop       (pop_i),
   .level     (level),
   .overrun   (overrun),
   .out_word  (out_q),
   .par_exact (exact[rxq_pkg::ERR_PAR]),
   .frm_exact (exact[rxq_pkg::ERR_FRM]),
   .status    (status_o)
);

// File: tb/rx_err_fifo_test.sv
module rx_err_fifo_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        push_i, push_perr_i, push_ferr_i, pop_i;
   logic [7:0]  push_data_i;
   logic [7:0]  pop_data_o;
   logic        pop_perr_o, pop_ferr_o;
   logic [15:0] status_o;

   always #4 clk = ~clk;

   rx_err_fifo uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_i),
      .push_data_i (push_data_i),
      .push_perr_i (push_perr_i),
      .push_ferr_i (push_ferr_i),
      .pop_i       (pop_i),
      .pop_data_o  (pop_data_o),
      .pop_perr_o  (pop_perr_o),
      .pop_ferr_o  (pop_ferr_o),
      .status_o    (status_o)
   );

   int n_chk = 0;
   int n_err = 0;

   // reference: entry = {parity flag, framing flag, byte}
   logic [9:0] sq[$];
   logic [9:0] exp_out;
   bit         exp_ovr;
   bit         running;
   bit         tag_paired, tag_fullpair, tag_emptypop;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int tally(int bitpos);
      int c = 0;
      foreach (sq[i]) if (sq[i][bitpos]) c++;
      return c;
   endfunction

   // driver: present one cycle of stimulus and advance the reference
   task automatic drive(bit ps, logic [7:0] d, bit pe, bit fe, bit pp);
      bit full, empty, pop_ok, push_ok;
      @(negedge clk);
      push_i = ps; push_data_i = d; push_perr_i = pe; push_ferr_i = fe; pop_i = pp;
      full    = (sq.size() == 16);
      empty   = (sq.size() == 0);
      pop_ok  = pp && !empty;
      push_ok = ps && (!full || pop_ok);
      tag_paired   = pop_ok && push_ok;
      tag_fullpair = full && pop_ok && push_ok;
      tag_emptypop = pp && empty;
      if (pop_ok) exp_out = sq.pop_front();
      if (push_ok) sq.push_back({pe, fe, d});
      if (ps && !push_ok) exp_ovr = 1'b1;
   endtask

   task automatic idle();
      drive(0, 8'h00, 0, 0, 0);
   endtask

   // monitor: compare the design against the reference after each edge
   always @(posedge clk) begin
      if (running) begin
         int pc, fc;
         #2;
         pc = tally(9);
         fc = tally(8);
         chk(pc >= 15 ? "R10 parity tally saturation" : "R3 parity tally",
             status_o[15:12], (pc > 15) ? 15 : pc);
         chk("R4 framing tally", status_o[11:8], (fc > 15) ? 15 : fc);
         chk("R6 level", status_o[4:0], sq.size());
         chk("R7 overrun", status_o[7], exp_ovr);
         chk("R11 reserved bits", status_o[6:5], 0);
         chk(tag_emptypop ? "R8 held pop output" : "R2 pop output",
             {pop_perr_o, pop_ferr_o, pop_data_o}, exp_out);
         if (tag_paired) chk("R5 paired push/pop level", status_o[4:0], sq.size());
         if (tag_fullpair) chk("R9 paired at full, no overrun change", status_o[7], exp_ovr);
      end
   end

   task automatic do_reset();
      running = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      push_i = 0; pop_i = 0; push_data_i = 0; push_perr_i = 0; push_ferr_i = 0;
      sq.delete();
      exp_out = '0; exp_ovr = 1'b0;
      tag_paired = 0; tag_fullpair = 0; tag_emptypop = 0;
      @(negedge clk);
      chk("R1 status after reset", status_o, 0);
      chk("R1 pop outputs after reset", {pop_perr_o, pop_ferr_o, pop_data_o}, 0);
      rst_n = 1'b1;
      running = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b1;
      do_reset();

      // R2: short burst of mixed flags, then drain in order
      for (int i = 0; i < 5; i++) drive(1, 8'h30 + 8'(i), i[0], i[1], 0);
      for (int i = 0; i < 5; i++) drive(0, 8'h00, 0, 0, 1);
      idle();

      // R10: fill with parity-flagged entries, exact tally reaches 16
      for (int i = 0; i < 16; i++) drive(1, 8'hA0 + 8'(i), 1, i[0], 0);
      // R7: push while full without pop is dropped
      drive(1, 8'hEE, 1, 1, 0);
      idle();
      // R9: push paired with pop at full
      drive(1, 8'h55, 0, 0, 1);
      // drain everything; tally 15, 15, 14 ...
      for (int i = 0; i < 16; i++) drive(0, 8'h00, 0, 0, 1);
      // R8: pops on empty hold the output
      drive(0, 8'h00, 0, 0, 1);
      drive(0, 8'h00, 0, 0, 1);
      // push and pop together at empty: push taken, output held
      drive(1, 8'h77, 1, 0, 1);
      // R5: paired traffic at a middle level
      drive(1, 8'h78, 0, 1, 0);
      drive(1, 8'h79, 1, 1, 1);
      drive(1, 8'h7A, 0, 0, 1);
      drive(1, 8'h7B, 1, 0, 1);
      for (int i = 0; i < 4; i++) drive(0, 8'h00, 0, 0, 1);

      // random traffic with fill-heavy and drain-heavy phases
      for (int ph = 0; ph < 12; ph++) begin
         for (int i = 0; i < 250; i++) begin
            int r = int'($urandom % 8);
            bit ps = ph[0] ? (r < 6) : (r < 2);
            bit pp = ph[0] ? (($urandom % 8) < 2) : (($urandom % 8) < 6);
            drive(ps, 8'($urandom), 1'($urandom), 1'($urandom), pp);
         end
      end
      idle();

      // R1: reset clears overrun, tallies and level
      do_reset();
      idle();

      running = 1'b0;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule